// File: doc/BRIEF.md
# Floating-Point Sign, Classify and Min/Max Unit

This block performs the single-precision floating-point operations that do no rounding: three sign-transfer variants, a classifier that reports one of ten categories as a one-hot mask, and minimum/maximum with the rule that a NaN loses to a number. Each request carries two 32-bit operand patterns, a 3-bit operation code and a valid strobe. Operands arrive as plain 32-bit patterns, with no wider register boxing.

The result, an invalid-operation flag and an output valid strobe are all registered. They appear exactly one clock after the request. When no request is presented, the result and flag keep their last values. The unit sits beside an arithmetic pipeline and handles the cheap operations in a single stage.

Top module: `fp_sign_class_minmax`

## Requirements
- R1: `res_valid` equals `req_valid` delayed by one clock. The result and flag of a request appear in the cycle after it is accepted.
- R2: While `rst` is high and after its release, `res_valid`, `result` and `invalid` are 0 until the first request completes.
- R3: Operation code 0 (copy-sign) returns bits 30..0 of `src_a` with bit 31 taken from `src_b`.
- R4: Operation code 1 (negated sign) returns bits 30..0 of `src_a` with bit 31 set to the inverse of `src_b` bit 31.
- R5: Operation code 2 (xor sign) returns bits 30..0 of `src_a` with bit 31 set to the XOR of both operand sign bits.
- R6: Operation code 3 (classify) returns a mask with exactly one of bits 9..0 set and bits 31..10 zero. The bit positions are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN. A NaN is quiet when mantissa bit 22 is set.
- R7: Operation code 4 (minimum) of two numbers returns the numerically smaller operand. Negative zero counts as smaller than positive zero.
- R8: Operation code 5 (maximum) of two numbers returns the numerically larger operand. Positive zero counts as larger than negative zero.
- R9: For minimum or maximum, when exactly one operand is a NaN (quiet or signaling), the result is the other operand.
- R10: For minimum or maximum, when both operands are NaN, the result is 0x7FC00000.
- R11: `invalid` is 1 for a minimum or maximum in which either operand is a signaling NaN. It is 0 for every other request.
- R12: Operation codes 6 and 7 return a result of 0 with `invalid` at 0.
- R13: In a cycle with `req_valid` low, `result` and `invalid` keep their previous values on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| src_a | input | 32 | First operand pattern |
| src_b | input | 32 | Second operand pattern |
| res_valid | output | 1 | Result strobe, one clock after the request |
| result | output | 32 | Float pattern, or class mask zero-extended |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Every result, flag and valid strobe is due exactly one clock after the request that produced it. A request with `req_valid` low leaves the result and flag unchanged. The bench drives each request on a falling edge and updates its behavioural model to the state expected after the next rising edge. At the following falling edge it compares all three outputs with that model, so each comparison lands one register stage after its stimulus. Directed cases cover the signed zeros, every class, NaN mixes and the unused codes. A long stream mixes random operands with special patterns and idle cycles.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  localparam logic [2:0] OP_SGN_COPY = 3'd0;
  localparam logic [2:0] OP_SGN_NEG  = 3'd1;
  localparam logic [2:0] OP_SGN_XOR  = 3'd2;
  localparam logic [2:0] OP_CLASS    = 3'd3;
  localparam logic [2:0] OP_MIN      = 3'd4;
  localparam logic [2:0] OP_MAX      = 3'd5;

  localparam int CLASS_W = 10;
  localparam int CB_NINF  = 0;
  localparam int CB_NNORM = 1;
  localparam int CB_NSUB  = 2;
  localparam int CB_NZERO = 3;
  localparam int CB_PZERO = 4;
  localparam int CB_PSUB  = 5;
  localparam int CB_PNORM = 6;
  localparam int CB_PINF  = 7;
  localparam int CB_SNAN  = 8;
  localparam int CB_QNAN  = 9;

  typedef struct packed {
    logic sign;
    logic is_inf;
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic is_sub;
  } fscm_info_t;
endpackage

// File: rtl/fscm_inspect.sv
module fscm_inspect
  import fscm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]  operand,
  output fscm_info_t            info,
  output logic [CLASS_W-1:0]    class_mask
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;
  logic exp_ones, exp_zero, man_zero;

  assign expo     = operand[W-2:MAN_W];
  assign mant     = operand[MAN_W-1:0];
  assign exp_ones = &expo;
  assign exp_zero = ~|expo;
  assign man_zero = ~|mant;

  always_comb begin
    info.sign    = operand[W-1];
    info.is_inf  = exp_ones & man_zero;
    info.is_nan  = exp_ones & ~man_zero;
    info.is_snan = exp_ones & ~man_zero & ~mant[MAN_W-1];
    info.is_zero = exp_zero & man_zero;
    info.is_sub  = exp_zero & ~man_zero;
  end

  always_comb begin
    class_mask = '0;
    if (info.is_nan) begin
      if (info.is_snan) class_mask[CB_SNAN] = 1'b1;
      else              class_mask[CB_QNAN] = 1'b1;
    end else if (info.is_inf) begin
      if (info.sign) class_mask[CB_NINF] = 1'b1;
      else           class_mask[CB_PINF] = 1'b1;
    end else if (info.is_zero) begin
      if (info.sign) class_mask[CB_NZERO] = 1'b1;
      else           class_mask[CB_PZERO] = 1'b1;
    end else if (info.is_sub) begin
      if (info.sign) class_mask[CB_NSUB] = 1'b1;
      else           class_mask[CB_PSUB] = 1'b1;
    end else begin
      if (info.sign) class_mask[CB_NNORM] = 1'b1;
      else           class_mask[CB_PNORM] = 1'b1;
    end
  end
endmodule

// File: rtl/fscm_sign_inject.sv
module fscm_sign_inject #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   mode,
  output logic [W-1:0] y
);
  logic new_sign;

  always_comb begin
    unique case (mode)
      2'd0:    new_sign = b[W-1];
      2'd1:    new_sign = ~b[W-1];
      default: new_sign = a[W-1] ^ b[W-1];
    endcase
  end

  assign y = {new_sign, a[W-2:0]};
endmodule

// File: rtl/fscm_minmax.sv
module fscm_minmax
  import fscm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  fscm_info_t           ia,
  input  fscm_info_t           ib,
  input  logic                 pick_max,
  output logic [EXP_W+MAN_W:0] y,
  output logic                 nv
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_below_b;
  logic mag_lt, mag_gt;

  assign mag_lt = a[W-2:0] < b[W-2:0];
  assign mag_gt = a[W-2:0] > b[W-2:0];

  always_comb begin
    if (ia.sign != ib.sign) a_below_b = ia.sign;
    else if (!ia.sign)      a_below_b = mag_lt;
    else                    a_below_b = mag_gt;
  end

  always_comb begin
    if (ia.is_nan && ib.is_nan) y = CANON_NAN;
    else if (ia.is_nan)         y = b;
    else if (ib.is_nan)         y = a;
    else if (pick_max)          y = a_below_b ? b : a;
    else                        y = a_below_b ? a : b;
  end

  assign nv = ia.is_snan | ib.is_snan;
endmodule

// File: rtl/fp_sign_class_minmax.sv
module fp_sign_class_minmax
  import fscm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [2:0]               op,
  input  logic [EXP_W+MAN_W:0]     src_a,
  input  logic [EXP_W+MAN_W:0]     src_b,
  output logic                     res_valid,
  output logic [EXP_W+MAN_W:0]     result,
  output logic                     invalid
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam int N_SRC = 2;

  logic [W-1:0]       operands [N_SRC];
  fscm_info_t         infos    [N_SRC];
  logic [CLASS_W-1:0] masks    [N_SRC];

  assign operands[0] = src_a;
  assign operands[1] = src_b;

  for (genvar g = 0; g < N_SRC; g++) begin : g_inspect
    fscm_inspect #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_inspect (
      .operand    (operands[g]),
      .info       (infos[g]),
      .class_mask (masks[g])
    );
  end

  logic [W-1:0] sgn_y;
  fscm_sign_inject #(.W(W)) u_sgn (
    .a    (src_a),
    .b    (src_b),
    .mode (op[1:0]),
    .y    (sgn_y)
  );

  logic [W-1:0] mm_y;
  logic         mm_nv;
  fscm_minmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mm (
    .a        (src_a),
    .b        (src_b),
    .ia       (infos[0]),
    .ib       (infos[1]),
    .pick_max (op == OP_MAX),
    .y        (mm_y),
    .nv       (mm_nv)
  );

  logic [W-1:0] next_res;
  logic         next_nv;

  always_comb begin
    next_res = '0;
    next_nv  = 1'b0;
    unique case (op)
      OP_SGN_COPY, OP_SGN_NEG, OP_SGN_XOR: next_res = sgn_y;
      OP_CLASS: next_res = {{(W-CLASS_W){1'b0}}, masks[0]};
      OP_MIN, OP_MAX: begin
        next_res = mm_y;
        next_nv  = mm_nv;
      end
      default: begin
        next_res = '0;
        next_nv  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        result  <= next_res;
        invalid <= next_nv;
      end
    end
  end
endmodule

// File: rtl/fp_sign_class_minmax_chk.sv
module fp_sign_class_minmax_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic [2:0]   op,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         res_valid,
  input logic [W-1:0] result,
  input logic         invalid
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  p_idle_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  p_sgn_magnitude_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op <= 3'd2) |=> result[W-2:0] == $past(src_a[W-2:0]));
  p_class_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == 3'd3) |=> ($countones(result) == 1 && result[W-1:10] == '0));
  p_nan_canonical_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (op == 3'd4 || op == 3'd5) && src_a[W-2:W-9] == 8'hFF && src_a[W-10:0] != '0
     && src_b[W-2:W-9] == 8'hFF && src_b[W-10:0] != '0) |=> result == 32'h7FC00000);
  p_no_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op != 3'd4 && op != 3'd5) |=> !invalid);
  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(result) && $stable(invalid)));
endmodule

bind fp_sign_class_minmax fp_sign_class_minmax_chk #(.W(EXP_W + MAN_W + 1)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .op        (op),
  .src_a     (src_a),
  .src_b     (src_b),
  .res_valid (res_valid),
  .result    (result),
  .invalid   (invalid)
);

// File: tb/fp_sign_class_minmax_test.sv
`timescale 1ns/1ps
module fp_sign_class_minmax_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        res_valid;
  logic [31:0] result;
  logic        invalid;

  int checks = 0;
  int failures = 0;
  logic        m_valid = 1'b0;
  logic [31:0] m_res = '0;
  logic        m_inv = 1'b0;
  string       m_tag = "R2";

  always #2.5 clk = ~clk;

  fp_sign_class_minmax uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op(op),
    .src_a(src_a), .src_b(src_b),
    .res_valid(res_valid), .result(result), .invalid(invalid)
  );

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction

  function automatic int class_idx(input logic [31:0] x);
    bit neg = x[31];
    if (is_nan(x)) return x[22] ? 9 : 8;
    if (x[30:23] == 8'hFF) return neg ? 0 : 7;
    if (x[30:0] == 0) return neg ? 3 : 4;
    if (x[30:23] == 0) return neg ? 2 : 5;
    return neg ? 1 : 6;
  endfunction

  // Ordering key: negative zero sorts just below positive zero.
  function automatic longint order_key(input logic [31:0] x);
    longint mag = longint'(x[30:0]);
    if (x[31]) return -(mag * 2) - 1;
    return mag * 2;
  endfunction

  task automatic model(input bit v, input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    m_valid = v;
    if (!v) return;
    m_inv = 1'b0;
    case (o)
      3'd0: m_res = {b[31], a[30:0]};
      3'd1: m_res = {~b[31], a[30:0]};
      3'd2: m_res = {a[31] ^ b[31], a[30:0]};
      3'd3: m_res = 32'd1 << class_idx(a);
      3'd4, 3'd5: begin
        if (is_nan(a) && is_nan(b)) m_res = 32'h7FC00000;
        else if (is_nan(a)) m_res = b;
        else if (is_nan(b)) m_res = a;
        else if (o == 3'd4) m_res = (order_key(a) <= order_key(b)) ? a : b;
        else m_res = (order_key(a) >= order_key(b)) ? a : b;
        m_inv = is_snan(a) || is_snan(b);
      end
      default: m_res = 32'd0;
    endcase
  endtask

  task automatic compare();
    checks++;
    if (res_valid !== m_valid || result !== m_res || invalid !== m_inv) begin
      failures++;
      $display("FAIL %s: got valid=%0b res=%08h inv=%0b, expected valid=%0b res=%08h inv=%0b",
               m_tag, res_valid, result, invalid, m_valid, m_res, m_inv);
    end
  endtask

  // Compare what the previous request produced, then drive the next one.
  task automatic step(input bit v, input logic [2:0] o, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    @(negedge clk);
    compare();
    req_valid = v; op = o; src_a = a; src_b = b;
    model(v, o, a, b);
    m_tag = tag;
  endtask

  function automatic logic [31:0] pick_val(input int unsigned r);
    case (r % 12)
      0: return 32'h00000000;
      1: return 32'h80000000;
      2: return 32'h7F800000;
      3: return 32'hFF800000;
      4: return 32'h7FC00000;
      5: return 32'h7F800001;
      6: return 32'hFFA00000;
      7: return 32'h00000001;
      8: return 32'h807FFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL R1: watchdog expired, got no completion, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                               // R2 reset state while in reset
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 3'd0, 32'h0, 32'h0, "R2");   // R2 state after release
    // R3 R4 R5 sign operations
    step(1'b1, 3'd0, 32'h3FC00000, 32'h80000000, "R3");
    step(1'b1, 3'd0, 32'hC0490FDB, 32'hC0490FDB, "R3");
    step(1'b1, 3'd1, 32'h40200000, 32'h40200000, "R4");
    step(1'b1, 3'd1, 32'h7F800000, 32'hBF800000, "R4");
    step(1'b1, 3'd2, 32'hC0200000, 32'hC0200000, "R5");
    step(1'b1, 3'd2, 32'h40200000, 32'h80000000, "R5");
    step(1'b1, 3'd2, 32'h7F800001, 32'h00000000, "R11");  // sNaN on sign op: no flag
    // R6 every class
    step(1'b1, 3'd3, 32'hFF800000, 32'h0, "R6");
    step(1'b1, 3'd3, 32'hBF800000, 32'h0, "R6");
    step(1'b1, 3'd3, 32'h80000001, 32'h0, "R6");
    step(1'b1, 3'd3, 32'h80000000, 32'h0, "R6");
    step(1'b1, 3'd3, 32'h00000000, 32'h0, "R6");
    step(1'b1, 3'd3, 32'h007FFFFF, 32'h0, "R6");
    step(1'b1, 3'd3, 32'h3F800000, 32'h0, "R6");
    step(1'b1, 3'd3, 32'h7F800000, 32'h0, "R6");
    step(1'b1, 3'd3, 32'h7FA00000, 32'h0, "R6");
    step(1'b1, 3'd3, 32'hFFC00001, 32'h0, "R6");
    // R7 R8 numbers and signed zeros
    step(1'b1, 3'd4, 32'h80000000, 32'h00000000, "R7");
    step(1'b1, 3'd4, 32'h00000000, 32'h80000000, "R7");
    step(1'b1, 3'd4, 32'hC0000000, 32'hBF800000, "R7");
    step(1'b1, 3'd4, 32'h3F800000, 32'h40000000, "R7");
    step(1'b1, 3'd5, 32'h80000000, 32'h00000000, "R8");
    step(1'b1, 3'd5, 32'h00000000, 32'h80000000, "R8");
    step(1'b1, 3'd5, 32'hC0000000, 32'hBF800000, "R8");
    step(1'b1, 3'd5, 32'hFF800000, 32'h00000001, "R8");
    // R9 R10 R11 NaN handling
    step(1'b1, 3'd4, 32'h7FC00000, 32'h40400000, "R9");
    step(1'b1, 3'd5, 32'hC0400000, 32'h7F800001, "R9");
    step(1'b1, 3'd4, 32'h7F800001, 32'hFFC12345, "R10");
    step(1'b1, 3'd5, 32'hFFC00000, 32'h7FC00001, "R10");
    step(1'b1, 3'd5, 32'h7FC00000, 32'h3F800000, "R11");
    // R12 unused codes
    step(1'b1, 3'd6, 32'h7F800001, 32'h12345678, "R12");
    step(1'b1, 3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, "R12");
    // R13 hold then R1 idle valid
    step(1'b1, 3'd4, 32'h7F800001, 32'h3F800000, "R11");
    step(1'b0, 3'd2, 32'h11111111, 32'h22222222, "R13");
    step(1'b0, 3'd3, 32'h0, 32'h0, "R13");
    // Mixed stream
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 5) != 0, 3'($urandom), pick_val($urandom), pick_val($urandom), "R1");
    end
    step(1'b0, 3'd0, 32'h0, 32'h0, "R1");
    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule